// File: doc/BRIEF.md
# Dirty Band Refresh Coalescer

This block keeps one dirty flag for each memory page of a framebuffer and turns those flags into a short list of screen update regions. A page of the 8-bit index plane holds four scanlines of a fixed 1024-pixel stride, so one flag stands for a horizontal band of four lines. A scan begins on a start pulse and checks one band per clock, from the top of the screen to the bottom. Each run of adjacent dirty bands becomes a single update region. The region leaves the block as a start line and a line count. The region width is the full line and is not sent.

The block can also run in a deep-colour mode. In that mode each band also owns four pages of a direct-colour plane and four pages of a per-pixel control plane. The band counts as dirty when any of these nine pages is dirty. Writers report a modified page through a mark port. An invalidate pulse sets every flag. When the scan is done, the block clears the flags in one cycle. The cleared range runs from the lowest dirty band to the highest dirty band, both included. In deep-colour mode the range is scaled by four for the two extra planes.

Top module: `dirty_band_coalescer`

## Requirements
- R1: After reset, busy, upd_valid and done are low and every flag is clean, so a scan produces no region.
- R2: A region made of dirty bands s to e reports upd_line = 4*s and upd_count = 4*(e-s+1).
- R3: Adjacent dirty bands merge into one region. A clean band closes the open run, so separate runs give separate regions, ordered from top to bottom.
- R4: A run still open at the last band is emitted with its count reaching the bottom line (4*NUM_BANDS).
- R5: With mode24 low at start, only the index plane (mark_plane 0) decides dirtiness. The direct-colour and control flags are neither used nor cleared.
- R6: With mode24 high at start, band b is dirty when index page b is dirty, or any direct-colour page (mark_plane 1) or control page (mark_plane 2) in 4b to 4b+3 is dirty.
- R7: At the end of a scan that found a dirty band, index flags from the lowest to the highest dirty band are cleared, both ends included. In deep-colour mode the extra-plane pages 4*min to 4*max+3 are also cleared. A scan that finds nothing clears nothing.
- R8: An invalidate pulse sets every flag in all planes, so the next scan emits one region: line 0, count 4*NUM_BANDS.
- R9: While upd_valid is high and upd_ready is low, upd_valid, upd_line and upd_count hold steady. Each accepted transfer carries exactly one region.
- R10: A mark or invalidate in the clear cycle (done high) survives the clear.
- R11: done is high for one cycle at the end of each scan, after which busy falls. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| mode24 | input | 1 | Deep-colour mode, latched at start |
| invalidate | input | 1 | Set every flag in all planes |
| mark_valid | input | 1 | Mark one page dirty |
| mark_plane | input | 2 | 0 index, 1 direct colour, 2 control |
| mark_page | input | PAGE_W | Page number within the plane |
| upd_valid | output | 1 | Region offered |
| upd_ready | input | 1 | Region accepted when valid |
| upd_line | output | LINE_W | First line of region |
| upd_count | output | LINE_W | Number of lines in region |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Clear cycle, end of scan |

## Verification
Errors in the run state show up directly in the region stream. A run-start register that is not updated gives a wrong upd_line on the very next region. A missed close merges two runs into one region. A bad min/max range or a wrong plane scale in the clear leaves flags set, and these come back as extra regions on the following scan. This is why each scan in the bench is followed by a second scan with no new marks, whose result is compared against the model.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    localparam int LINES_PER_BAND = 4;
    localparam int SUBPAGES       = 4;

    typedef enum logic [1:0] {
        PL_INDEX  = 2'd0,
        PL_DIRECT = 2'd1,
        PL_CTRL   = 2'd2
    } plane_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_EMIT,
        ST_CLEAR
    } scan_state_e;
endpackage

// File: rtl/dbc_flag_store.sv
module dbc_flag_store
    import dbc_pkg::*;
#(
    parameter int NUM_BANDS = 192,
    parameter int PAGE_W    = 10,
    parameter int BAND_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              invalidate,
    input  logic              mark_valid,
    input  logic [1:0]        mark_plane,
    input  logic [PAGE_W-1:0] mark_page,
    input  logic [BAND_W-1:0] rd_band,
    input  logic              rd_mode24,
    input  logic              clr_en,
    input  logic              clr24,
    input  logic [BAND_W-1:0] clr_lo,
    input  logic [BAND_W-1:0] clr_hi,
    output logic              band_dirty
);
    localparam int XPAGES = NUM_BANDS * SUBPAGES;
    localparam int IDX_W  = $clog2(NUM_BANDS);

    logic [NUM_BANDS-1:0] idx_q;
    logic [XPAGES-1:0]    dir_q, ctl_q;

    for (genvar i = 0; i < NUM_BANDS; i++) begin : g_idx
        logic set_i, clr_i;
        assign set_i = invalidate ||
                       (mark_valid && mark_plane == PL_INDEX && mark_page == PAGE_W'(i));
        assign clr_i = clr_en && (BAND_W'(i) >= clr_lo) && (BAND_W'(i) <= clr_hi);
        always_ff @(posedge clk) begin
            if (rst)        idx_q[i] <= 1'b0;
            else if (set_i) idx_q[i] <= 1'b1;
            else if (clr_i) idx_q[i] <= 1'b0;
        end
    end

    for (genvar j = 0; j < XPAGES; j++) begin : g_ext
        localparam int BAND_OF_J = j / SUBPAGES;
        logic set_d, set_c, clr_j;
        assign set_d = invalidate ||
                       (mark_valid && mark_plane == PL_DIRECT && mark_page == PAGE_W'(j));
        assign set_c = invalidate ||
                       (mark_valid && mark_plane == PL_CTRL && mark_page == PAGE_W'(j));
        assign clr_j = clr_en && clr24 &&
                       (BAND_W'(BAND_OF_J) >= clr_lo) && (BAND_W'(BAND_OF_J) <= clr_hi);
        always_ff @(posedge clk) begin
            if (rst) begin
                dir_q[j] <= 1'b0;
                ctl_q[j] <= 1'b0;
            end else begin
                if (set_d)      dir_q[j] <= 1'b1;
                else if (clr_j) dir_q[j] <= 1'b0;
                if (set_c)      ctl_q[j] <= 1'b1;
                else if (clr_j) ctl_q[j] <= 1'b0;
            end
        end
    end

    logic             in_range;
    logic [IDX_W-1:0] ri;
    logic             ext_hit;

    always_comb begin
        in_range   = rd_band < BAND_W'(NUM_BANDS);
        ri         = in_range ? rd_band[IDX_W-1:0] : '0;
        ext_hit    = (|dir_q[int'(ri)*SUBPAGES +: SUBPAGES]) ||
                     (|ctl_q[int'(ri)*SUBPAGES +: SUBPAGES]);
        band_dirty = in_range && (idx_q[ri] || (rd_mode24 && ext_hit));
    end
endmodule

// File: rtl/dbc_band_scanner.sv
module dbc_band_scanner
    import dbc_pkg::*;
#(
    parameter int NUM_BANDS = 192,
    parameter int BAND_W    = 8,
    parameter int LINE_W    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode24,
    input  logic              band_dirty,
    input  logic              upd_ready,
    output logic [BAND_W-1:0] rd_band,
    output logic              rd_mode24,
    output logic              upd_valid,
    output logic [LINE_W-1:0] upd_line,
    output logic [LINE_W-1:0] upd_count,
    output logic              busy,
    output logic              done,
    output logic              clr_en,
    output logic [BAND_W-1:0] clr_lo,
    output logic [BAND_W-1:0] clr_hi
);
    scan_state_e       state_q;
    logic [BAND_W-1:0] band_q, run_start_q, pmin_q, pmax_q;
    logic              run_open_q, seen_q, mode_q;
    logic [LINE_W-1:0] line_q, count_q;
    logic              at_end;

    assign at_end = band_q == BAND_W'(NUM_BANDS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            band_q      <= '0;
            run_start_q <= '0;
            pmin_q      <= '0;
            pmax_q      <= '0;
            run_open_q  <= 1'b0;
            seen_q      <= 1'b0;
            mode_q      <= 1'b0;
            line_q      <= '0;
            count_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q    <= ST_SCAN;
                    band_q     <= '0;
                    run_open_q <= 1'b0;
                    seen_q     <= 1'b0;
                    mode_q     <= mode24;
                end
                ST_SCAN: begin
                    if (band_dirty) begin
                        if (!run_open_q) begin
                            run_open_q  <= 1'b1;
                            run_start_q <= band_q;
                        end
                        if (!seen_q) pmin_q <= band_q;
                        pmax_q <= band_q;
                        seen_q <= 1'b1;
                        band_q <= band_q + 1'b1;
                    end else if (run_open_q) begin
                        line_q     <= LINE_W'(int'(run_start_q) * LINES_PER_BAND);
                        count_q    <= LINE_W'(int'(band_q - run_start_q) * LINES_PER_BAND);
                        run_open_q <= 1'b0;
                        state_q    <= ST_EMIT;
                    end else if (at_end) begin
                        state_q <= ST_CLEAR;
                    end else begin
                        band_q <= band_q + 1'b1;
                    end
                end
                ST_EMIT: if (upd_ready) begin
                    if (at_end) state_q <= ST_CLEAR;
                    else begin
                        band_q  <= band_q + 1'b1;
                        state_q <= ST_SCAN;
                    end
                end
                ST_CLEAR: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_band   = band_q;
    assign rd_mode24 = mode_q;
    assign upd_valid = state_q == ST_EMIT;
    assign upd_line  = line_q;
    assign upd_count = count_q;
    assign busy      = state_q != ST_IDLE;
    assign done      = state_q == ST_CLEAR;
    assign clr_en    = done && seen_q;
    assign clr_lo    = pmin_q;
    assign clr_hi    = pmax_q;
endmodule

// File: rtl/dirty_band_coalescer.sv
module dirty_band_coalescer
    import dbc_pkg::*;
#(
    parameter int NUM_BANDS = 192,
    parameter int PAGE_W    = $clog2(NUM_BANDS * SUBPAGES),
    parameter int LINE_W    = $clog2(NUM_BANDS * LINES_PER_BAND + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode24,
    input  logic              invalidate,
    input  logic              mark_valid,
    input  logic [1:0]        mark_plane,
    input  logic [PAGE_W-1:0] mark_page,
    output logic              upd_valid,
    input  logic              upd_ready,
    output logic [LINE_W-1:0] upd_line,
    output logic [LINE_W-1:0] upd_count,
    output logic              busy,
    output logic              done
);
    localparam int BAND_W = $clog2(NUM_BANDS + 1);

    logic [BAND_W-1:0] rd_band, clr_lo, clr_hi;
    logic              rd_mode24, band_dirty, clr_en;

    dbc_flag_store #(.NUM_BANDS(NUM_BANDS), .PAGE_W(PAGE_W), .BAND_W(BAND_W)) u_store (
        .clk(clk), .rst(rst), .invalidate(invalidate), .mark_valid(mark_valid),
        .mark_plane(mark_plane), .mark_page(mark_page), .rd_band(rd_band),
        .rd_mode24(rd_mode24), .clr_en(clr_en), .clr24(rd_mode24),
        .clr_lo(clr_lo), .clr_hi(clr_hi), .band_dirty(band_dirty)
    );

    dbc_band_scanner #(.NUM_BANDS(NUM_BANDS), .BAND_W(BAND_W), .LINE_W(LINE_W)) u_scan (
        .clk(clk), .rst(rst), .start(start), .mode24(mode24), .band_dirty(band_dirty),
        .upd_ready(upd_ready), .rd_band(rd_band), .rd_mode24(rd_mode24),
        .upd_valid(upd_valid), .upd_line(upd_line), .upd_count(upd_count),
        .busy(busy), .done(done), .clr_en(clr_en), .clr_lo(clr_lo), .clr_hi(clr_hi)
    );
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
    parameter int NUM_BANDS = 192,
    parameter int LINE_W    = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              upd_valid,
    input logic              upd_ready,
    input logic [LINE_W-1:0] upd_line,
    input logic [LINE_W-1:0] upd_count
);
    localparam int HEIGHT = NUM_BANDS * 4;

    p_reset_quiet_r1: assert property (@(posedge clk) $past(rst) |-> !busy && !upd_valid && !done);

    p_region_shape_r2: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> upd_count != '0 && upd_count[1:0] == 2'b00 && upd_line[1:0] == 2'b00);

    p_region_bound_r4: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (32'(upd_line) + 32'(upd_count)) <= HEIGHT);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        upd_valid && !upd_ready |=> upd_valid && $stable(upd_line) && $stable(upd_count));

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    p_idle_silent_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !upd_valid && !done);
endmodule

bind dirty_band_coalescer dbc_checker #(.NUM_BANDS(NUM_BANDS), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_line(upd_line), .upd_count(upd_count)
);

// File: tb/dirty_band_coalescer_test.sv
module dirty_band_coalescer_test;
    localparam int NB = 192;
    localparam int XP = NB * 4;
    localparam int PW = 10;
    localparam int LW = 10;

    logic clk = 0, rst = 1, start = 0, mode24 = 0, invalidate = 0;
    logic mark_valid = 0, upd_ready = 0;
    logic [1:0] mark_plane = 0;
    logic [PW-1:0] mark_page = 0;
    logic upd_valid, busy, done;
    logic [LW-1:0] upd_line, upd_count;

    int checks = 0, errors = 0;
    bit m_idx[NB];
    bit m_dir[XP];
    bit m_ctl[XP];

    always #2.5 clk = ~clk;

    dirty_band_coalescer #(.NUM_BANDS(NB)) uut (
        .clk(clk), .rst(rst), .start(start), .mode24(mode24), .invalidate(invalidate),
        .mark_valid(mark_valid), .mark_plane(mark_plane), .mark_page(mark_page),
        .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_line(upd_line),
        .upd_count(upd_count), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mark(input int plane, input int page);
        @(negedge clk);
        mark_valid = 1; mark_plane = 2'(plane); mark_page = PW'(page);
        @(negedge clk);
        mark_valid = 0;
        if (plane == 0) m_idx[page] = 1;
        else if (plane == 1) m_dir[page] = 1;
        else m_ctl[page] = 1;
    endtask

    task automatic do_invalidate();
        @(negedge clk);
        invalidate = 1;
        @(negedge clk);
        invalidate = 0;
        foreach (m_idx[i]) m_idx[i] = 1;
        foreach (m_dir[i]) begin m_dir[i] = 1; m_ctl[i] = 1; end
    endtask

    function automatic bit band_dirty(input int b, input bit m24);
        bit e = 0;
        for (int k = 0; k < 4; k++) e |= m_dir[4*b+k] | m_ctl[4*b+k];
        return m_idx[b] | (m24 & e);
    endfunction

    // Scan, compare regions, apply the model clear. done_page >= 0 marks an
    // index page in the clear cycle (R10).
    task automatic scan(input bit m24, input int ready_pct, input int done_page, input string tag);
        int el[$], ec[$], gl[$], gc[$];
        int rs = -1, mn = -1, mx = -1, cyc = 0;
        bit stall = 0;
        int sl = 0, sc = 0;
        for (int b = 0; b <= NB; b++) begin
            bit d = (b < NB) ? band_dirty(b, m24) : 1'b0;
            if (d) begin
                if (rs < 0) rs = b;
                if (mn < 0) mn = b;
                mx = b;
            end else if (rs >= 0) begin
                el.push_back(rs * 4); ec.push_back((b - rs) * 4); rs = -1;
            end
        end
        @(negedge clk);
        start = 1; mode24 = m24;
        @(negedge clk);
        start = 0;
        forever begin
            cyc++;
            if (cyc == 4) start = 1;           // R11: ignored while busy
            if (cyc == 5) start = 0;
            if (stall) begin
                check(upd_valid && upd_line == LW'(sl) && upd_count == LW'(sc),
                      "R9 hold", int'(upd_line), sl);
            end
            upd_ready = ($urandom_range(99) < ready_pct);
            stall = upd_valid && !upd_ready;
            sl = int'(upd_line); sc = int'(upd_count);
            if (upd_valid && upd_ready) begin
                gl.push_back(int'(upd_line)); gc.push_back(int'(upd_count));
            end
            if (done) begin
                if (done_page >= 0) begin
                    mark_valid = 1; mark_plane = 0; mark_page = PW'(done_page);
                end
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        mark_valid = 0; upd_ready = 0;
        check(!busy && !done, {"R11 end ", tag}, int'(busy), 0);
        check(gl.size() == el.size(), {"R3 region count ", tag}, gl.size(), el.size());
        for (int i = 0; i < el.size() && i < gl.size(); i++) begin
            check(gl[i] == el[i], {"R2 line ", tag}, gl[i], el[i]);
            check(gc[i] == ec[i], {"R2 count ", tag}, gc[i], ec[i]);
        end
        if (mn >= 0) begin
            for (int p = mn; p <= mx; p++) m_idx[p] = 0;
            if (m24) for (int p = 4*mn; p <= 4*mx+3; p++) begin m_dir[p] = 0; m_ctl[p] = 0; end
        end
        if (done_page >= 0) m_idx[done_page] = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !upd_valid && !done, "R1 reset outputs", int'(busy), 0);
        scan(1, 100, -1, "R1 empty after reset");

        mark(0, 0);
        scan(0, 100, -1, "R2 first band");
        mark(0, NB-1);
        scan(0, 60, -1, "R4 last band");
        mark(0, 10); mark(0, 11); mark(0, 12); mark(0, 20); mark(0, 22);
        scan(0, 50, -1, "R3 runs");
        scan(0, 100, -1, "R7 rescan empty");

        mark(1, 4*30+2); mark(2, 4*40+3);
        scan(0, 100, -1, "R5 extras ignored");
        scan(1, 100, -1, "R6 extras seen");
        scan(1, 100, -1, "R7 extras cleared");

        mark(0, 50); mark(2, 4*52); mark(1, 4*51+1);
        scan(1, 70, -1, "R6 mixed merge");

        do_invalidate();
        scan(0, 100, -1, "R8 invalidate 8bit");
        scan(1, 100, -1, "R8 extras still set");
        do_invalidate();
        scan(1, 30, -1, "R8 invalidate 24bit");

        mark(0, 5); mark(0, 100);
        scan(0, 100, 60, "R10 mark in clear");
        scan(0, 100, -1, "R10 survivor");

        for (int it = 0; it < 25; it++) begin
            int n = $urandom_range(12);
            for (int k = 0; k < n; k++) begin
                int pl = $urandom_range(2);
                mark(pl, (pl == 0) ? $urandom_range(NB-1) : $urandom_range(XP-1));
            end
            scan(1'($urandom_range(1)), 40 + $urandom_range(60), -1, "R3 random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule